// File: doc/BRIEF.md
# Twelve-Bit Coefficient Byte Packer

This block turns a stream of 12-bit polynomial coefficients into a byte stream. Coefficients arrive one per transfer on a valid/ready input. Each pair of them is packed into three bytes, low bits first, and the bytes leave on a valid/ready output. The block is used at the end of a key-generation datapath. It serialises K polynomials of 256 coefficients each, then closes the frame with a 32-byte seed.

A frame begins with a start pulse while the block is idle. In that cycle the block samples a 3-bit rank and a 256-bit seed. The rank sets how many coefficients are consumed (256 per polynomial), and so how long the frame is: 800, 1184 or 1568 bytes for ranks 2, 3 and 4. The final seed byte carries a last marker, and the block then goes back to idle. The block never stores a whole polynomial. It holds the first coefficient of a pair and at most three bytes waiting to leave.

Top module: `coef_byte_packer`

## Requirements
- R1: While reset is held, and afterwards until a start is accepted, `coef_ready_o`, `byte_valid_o` and `byte_last_o` are all low.
- R2: Call a pair's coefficients a (the earlier one) and b. The pair leaves as three consecutive bytes, in this order: a[7:0], then {b[3:0], a[11:8]}, then b[11:4].
- R3: The rank is sampled at the accepted start, and exactly 256·K coefficients are accepted in the frame. A rank below 2 behaves as 2 and a rank above 4 behaves as 4.
- R4: After the packed bytes come 32 seed bytes. Seed byte m equals bits 8m+7:8m of the seed value sampled at start. Changes on the seed input later in the frame have no effect.
- R5: A frame carries 384·K+32 bytes. `byte_last_o` is high only together with the final seed byte.
- R6: `coef_ready_o` is high only while the frame still needs coefficients. When the first coefficient of a pair is held, it is also low unless no packed byte is pending, or exactly one is pending and `byte_ready_i` is high.
- R7: While `byte_valid_o` is high and `byte_ready_i` is low, the data and last outputs hold their values into the next cycle.
- R8: A start pulse during a frame is ignored. After the handshake of the last byte, the block is idle and accepts a start in the very next cycle.
- R9: If `byte_ready_i` stays high and a coefficient is offered whenever one is requested, one byte leaves in every cycle, from the first packed byte to the last seed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a frame when the block is idle |
| rank_i | input | 3 | Polynomial count, sampled at start |
| seed_i | input | 256 | Seed appended after the polynomials, sampled at start |
| coef_valid_i | input | 1 | Coefficient offered |
| coef_data_i | input | 12 | Coefficient value |
| coef_ready_o | output | 1 | Coefficient will be accepted this cycle |
| byte_valid_o | output | 1 | Output byte present |
| byte_data_o | output | 8 | Output byte |
| byte_last_o | output | 1 | Marks the final byte of the frame |
| byte_ready_i | input | 1 | Downstream accepts the byte |

## Verification
In one cycle the last pending byte of a pair can leave while the second coefficient of the next pair is accepted and refills the buffer. Likewise, the final packed byte can leave in the same cycle that the sequencer moves to the seed tail. The bench provokes both with full-rate frames and with frames in which output readiness and input validity are switched by a pseudo-random sequence. A behavioural queue model predicts input readiness, output validity, every byte and the last marker in every cycle. A refill that lands one cycle early or late therefore shows up as a mismatch in readiness or in byte order. A lost or extra byte at the seed boundary shows up in the frame-length check.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PACK = 2'd1,
        PH_SEED = 2'd2
    } phase_e;
endpackage

// File: rtl/cbp_pair_join.sv
module cbp_pair_join #(
    parameter int COEF_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  take_i,
    input  logic [COEF_W-1:0]     coef_i,
    output logic                  have_o,
    output logic                  fire_o,
    output logic [2*COEF_W-1:0]   pair_o
);
    typedef struct packed {
        logic              have;
        logic [COEF_W-1:0] lo;
    } join_t;

    join_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.have = 1'b0;
        end else if (take_i) begin
            if (st_q.have) begin
                st_d.have = 1'b0;
            end else begin
                st_d.have = 1'b1;
                st_d.lo   = coef_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign have_o = st_q.have;
    assign fire_o = take_i && st_q.have && !clear_i;
    // earlier coefficient in the low half gives least-significant-first bytes
    assign pair_o = {coef_i, st_q.lo};

    // R2
    hold_after_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !st_q.have && !clear_i) |=> (have_o && pair_o[COEF_W-1:0] == $past(coef_i)));
endmodule

// File: rtl/cbp_byte_shift.sv
module cbp_byte_shift #(
    parameter int PAIR_BYTES = 3,
    localparam int WORD_W    = PAIR_BYTES * 8,
    localparam int CNT_W     = $clog2(PAIR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              pop_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [7:0]        head_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] word;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.cnt = '0;
        end else begin
            if (pop_i) begin
                st_d.word = st_q.word >> 8;
                st_d.cnt  = st_q.cnt - CNT_W'(1);
            end
            if (load_i) begin
                st_d.word = word_i;
                st_d.cnt  = CNT_W'(PAIR_BYTES);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign head_o = st_q.word[7:0];

    // R6
    refill_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (st_q.cnt == '0 || (st_q.cnt == CNT_W'(1) && pop_i)));

    // R7
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (st_q.cnt != '0));
endmodule

// File: rtl/cbp_seq.sv
module cbp_seq
    import cbp_pkg::*;
#(
    parameter int RANK_W     = 3,
    parameter int RANK_MIN   = 2,
    parameter int RANK_MAX   = 4,
    parameter int NCOEF      = 256,
    parameter int SEED_BYTES = 32,
    localparam int SEED_W    = SEED_BYTES * 8,
    localparam int SIDX_W    = $clog2(SEED_BYTES),
    localparam int TAKE_W    = $clog2(NCOEF * RANK_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [RANK_W-1:0] rank_i,
    input  logic [SEED_W-1:0] seed_i,
    input  logic              coef_take_i,
    input  logic              drain_i,
    input  logic              seed_pop_i,
    output phase_e            phase_o,
    output logic              more_coef_o,
    output logic [7:0]        seed_byte_o,
    output logic              seed_last_o
);
    typedef struct packed {
        phase_e            phase;
        logic [RANK_W-1:0] rank;
        logic [TAKE_W-1:0] taken;
        logic [SIDX_W-1:0] sidx;
        logic [SEED_W-1:0] seed;
    } seq_t;

    seq_t st_d, st_q;
    logic [TAKE_W-1:0] total_w;

    function automatic logic [RANK_W-1:0] clamp_rank(input logic [RANK_W-1:0] r);
        if (r < RANK_W'(RANK_MIN))      return RANK_W'(RANK_MIN);
        else if (r > RANK_W'(RANK_MAX)) return RANK_W'(RANK_MAX);
        else                            return r;
    endfunction

    assign total_w = TAKE_W'(st_q.rank) * TAKE_W'(NCOEF);

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_PACK;
                    st_d.rank  = clamp_rank(rank_i);
                    st_d.taken = '0;
                    st_d.sidx  = '0;
                    st_d.seed  = seed_i;
                end
            end
            PH_PACK: begin
                if (coef_take_i) st_d.taken = st_q.taken + TAKE_W'(1);
                if (st_d.taken == total_w && drain_i) begin
                    st_d.phase = PH_SEED;
                    st_d.sidx  = '0;
                end
            end
            PH_SEED: begin
                if (seed_pop_i) begin
                    if (st_q.sidx == SIDX_W'(SEED_BYTES - 1)) st_d.phase = PH_IDLE;
                    else st_d.sidx = st_q.sidx + SIDX_W'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o     = st_q.phase;
    assign more_coef_o = (st_q.phase == PH_PACK) && (st_q.taken < total_w);
    assign seed_byte_o = st_q.seed[st_q.sidx*8 +: 8];
    assign seed_last_o = (st_q.phase == PH_SEED) && (st_q.sidx == SIDX_W'(SEED_BYTES - 1));

    // R3
    coef_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coef_take_i |-> (st_q.phase == PH_PACK && st_q.taken < total_w));

    // R5
    all_coefs_before_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_SEED) |-> (st_q.taken == total_w));

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_IDLE && start_i) |=> $stable(st_q.rank));
endmodule

// File: rtl/coef_byte_packer.sv
module coef_byte_packer
    import cbp_pkg::*;
#(
    parameter int COEF_W     = 12,
    parameter int NCOEF      = 256,
    parameter int RANK_W     = 3,
    parameter int RANK_MIN   = 2,
    parameter int RANK_MAX   = 4,
    parameter int SEED_BYTES = 32,
    localparam int PAIR_BYTES = (2 * COEF_W) / 8,
    localparam int CNT_W      = $clog2(PAIR_BYTES + 1),
    localparam int SEED_W     = SEED_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [RANK_W-1:0] rank_i,
    input  logic [SEED_W-1:0] seed_i,
    input  logic              coef_valid_i,
    input  logic [COEF_W-1:0] coef_data_i,
    output logic              coef_ready_o,
    output logic              byte_valid_o,
    output logic [7:0]        byte_data_o,
    output logic              byte_last_o,
    input  logic              byte_ready_i
);
    phase_e             phase;
    logic               more_coef;
    logic [7:0]         seed_byte;
    logic               seed_last;
    logic               have_first;
    logic               pair_fire;
    logic [2*COEF_W-1:0] pair_word;
    logic [CNT_W-1:0]   pend_cnt;
    logic [7:0]         head_byte;
    logic               coef_take;
    logic               buf_pop;
    logic               seed_pop;
    logic               drain;
    logic               idle_clr;
    logic               room;

    assign idle_clr  = (phase == PH_IDLE);
    assign room      = (pend_cnt == '0) || (pend_cnt == CNT_W'(1) && byte_ready_i);
    assign coef_ready_o = more_coef && (!have_first || room);
    assign coef_take = coef_valid_i && coef_ready_o;
    assign buf_pop   = (phase == PH_PACK) && (pend_cnt != '0) && byte_ready_i;
    assign seed_pop  = (phase == PH_SEED) && byte_ready_i;
    assign drain     = !pair_fire && ((pend_cnt == '0) || (pend_cnt == CNT_W'(1) && buf_pop));

    assign byte_valid_o = ((phase == PH_PACK) && (pend_cnt != '0)) || (phase == PH_SEED);
    assign byte_data_o  = (phase == PH_SEED) ? seed_byte : head_byte;
    assign byte_last_o  = seed_last;

    cbp_seq #(
        .RANK_W(RANK_W), .RANK_MIN(RANK_MIN), .RANK_MAX(RANK_MAX),
        .NCOEF(NCOEF), .SEED_BYTES(SEED_BYTES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rank_i(rank_i), .seed_i(seed_i),
        .coef_take_i(coef_take), .drain_i(drain), .seed_pop_i(seed_pop),
        .phase_o(phase), .more_coef_o(more_coef), .seed_byte_o(seed_byte),
        .seed_last_o(seed_last)
    );

    cbp_pair_join #(.COEF_W(COEF_W)) u_join (
        .clk(clk), .rst_n(rst_n), .clear_i(idle_clr), .take_i(coef_take),
        .coef_i(coef_data_i), .have_o(have_first), .fire_o(pair_fire), .pair_o(pair_word)
    );

    cbp_byte_shift #(.PAIR_BYTES(PAIR_BYTES)) u_shift (
        .clk(clk), .rst_n(rst_n), .clear_i(idle_clr), .load_i(pair_fire),
        .word_i(pair_word), .pop_i(buf_pop), .cnt_o(pend_cnt), .head_o(head_byte)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (!coef_ready_o && !byte_valid_o && !byte_last_o));

    // R7
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_o && !byte_ready_i) |=>
            (byte_valid_o && $stable(byte_data_o) && $stable(byte_last_o)));

    // R5
    last_only_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_last_o |-> (byte_valid_o && phase == PH_SEED));

    // R6
    ready_in_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coef_ready_o |-> (phase == PH_PACK));
endmodule

// File: tb/sim_coef_byte_packer.sv
module sim_coef_byte_packer;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         start_i;
    logic [2:0]   rank_i;
    logic [255:0] seed_i;
    logic         coef_valid_i;
    logic [11:0]  coef_data_i;
    logic         coef_ready_o;
    logic         byte_valid_o;
    logic [7:0]   byte_data_o;
    logic         byte_last_o;
    logic         byte_ready_i;

    always #4 clk = ~clk;

    coef_byte_packer u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rank_i(rank_i), .seed_i(seed_i),
        .coef_valid_i(coef_valid_i), .coef_data_i(coef_data_i), .coef_ready_o(coef_ready_o),
        .byte_valid_o(byte_valid_o), .byte_data_o(byte_data_o), .byte_last_o(byte_last_o),
        .byte_ready_i(byte_ready_i)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [15:0] lfsr = 16'hACE1;

    // behavioural reference state
    int m_phase = 0, m_have = 0, m_pend = 0, m_taken = 0, m_total = 0, m_sidx = 0;
    logic [11:0]  m_hold;
    logic [255:0] m_seed;
    logic [7:0]   q[$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0] | lfsr[3];
    endfunction

    function automatic int eff_rank(input int r);
        if (r < 2) return 2;
        if (r > 4) return 4;
        return r;
    endfunction

    function automatic logic [11:0] coef_val(input int fr, input int idx);
        if (idx % 64 == 0) return 12'hFFF;
        if (idx % 64 == 1) return 12'h000;
        return 12'((idx * 1237 + fr * 611 + 77) % 4096);
    endfunction

    task automatic run_frame(input int rank_in, input logic [255:0] seed_in, input int mode, input int fr);
        int cyc = 0;
        bit started = 0;
        int nbytes = 0;
        int first_b = -1;
        int last_b = -1;
        int exp_len = 384 * eff_rank(rank_in) + 32;
        bit prev_stall = 0;
        logic [7:0] prev_data = 0;
        bit prev_last = 0;
        forever begin
            bit ex_ready, ex_valid, ex_last, pop, acc;
            @(negedge clk);
            start_i      = (cyc == 0) || (mode == 1 && cyc == 100);
            rank_i       = (cyc == 0) ? 3'(rank_in) : 3'd7;
            seed_i       = (cyc == 0) ? seed_in : ~seed_in;
            coef_valid_i = (mode == 0) ? 1'b1 : rnd();
            coef_data_i  = coef_val(fr, m_taken);
            byte_ready_i = (mode == 0) ? 1'b1 : (mode == 2 ? (rnd() & rnd()) : rnd());
            #1;
            ex_ready = (m_phase == 1) && (m_taken < m_total) &&
                       (m_have == 0 || m_pend == 0 || (m_pend == 1 && byte_ready_i));
            ex_valid = (m_phase == 1 && m_pend > 0) || (m_phase == 2);
            ex_last  = (m_phase == 2) && (m_sidx == 31);
            chk(coef_ready_o == ex_ready, "R6", "coef_ready", coef_ready_o, ex_ready);
            chk(byte_valid_o == ex_valid, "R9", "byte_valid", byte_valid_o, ex_valid);
            chk(byte_last_o == ex_last, "R5", "byte_last", byte_last_o, ex_last);
            if (ex_valid && byte_valid_o && q.size() > 0)
                chk(byte_data_o == q[0], (m_phase == 2) ? "R4" : "R2", "byte_data", byte_data_o, q[0]);
            if (prev_stall) begin
                chk(byte_data_o == prev_data, "R7", "stalled data", byte_data_o, prev_data);
                chk(byte_last_o == prev_last, "R7", "stalled last", byte_last_o, prev_last);
            end
            prev_stall = byte_valid_o && !byte_ready_i;
            prev_data  = byte_data_o;
            prev_last  = byte_last_o;
            pop = ex_valid && byte_ready_i;
            acc = ex_ready && coef_valid_i;
            if (pop) begin
                if (q.size() > 0) void'(q.pop_front());
                nbytes++;
                if (first_b < 0) first_b = cyc;
                last_b = cyc;
            end
            case (m_phase)
                0: if (start_i) begin
                    m_phase = 1; m_total = 256 * eff_rank(int'(rank_i));
                    m_taken = 0; m_have = 0; m_pend = 0; m_seed = seed_i; started = 1;
                end
                1: begin
                    if (pop) m_pend--;
                    if (acc) begin
                        if (m_have == 0) begin
                            m_hold = coef_data_i; m_have = 1;
                        end else begin
                            q.push_back(m_hold[7:0]);
                            q.push_back({coef_data_i[3:0], m_hold[11:8]});
                            q.push_back(coef_data_i[11:4]);
                            m_pend += 3; m_have = 0;
                        end
                        m_taken++;
                    end
                    if (m_taken == m_total && m_pend == 0) begin
                        m_phase = 2; m_sidx = 0;
                        for (int m = 0; m < 32; m++) q.push_back(m_seed[8*m +: 8]);
                    end
                end
                default: if (pop) begin
                    m_sidx++;
                    if (m_sidx == 32) m_phase = 0;
                end
            endcase
            cyc++;
            if (started && m_phase == 0) break;
            if (cyc > 30000) begin
                chk(0, "R5", "frame did not finish, cycles", cyc, exp_len);
                break;
            end
        end
        // R3 R5: frame length follows the sampled (clamped) rank
        chk(nbytes == exp_len, (mode == 1) ? "R8" : "R3", "frame length", nbytes, exp_len);
        if (mode == 0)
            chk(last_b - first_b + 1 == exp_len, "R9", "cycles first..last byte", last_b - first_b + 1, exp_len);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual no completion expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start_i = 0; rank_i = 3'd2; seed_i = '0;
        coef_valid_i = 0; coef_data_i = '0; byte_ready_i = 1;
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        chk(!coef_ready_o && !byte_valid_o && !byte_last_o, "R1", "outputs in reset",
            {coef_ready_o, byte_valid_o, byte_last_o}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!coef_ready_o && !byte_valid_o && !byte_last_o, "R1", "outputs after reset",
            {coef_ready_o, byte_valid_o, byte_last_o}, 0);
        run_frame(2, {8{32'h1357_9BDF}} ^ 256'h0123_4567, 0, 1);
        run_frame(3, {8{32'hDEAD_BEEF}}, 1, 2);       // R4 seed change, R8 mid-frame start
        run_frame(4, {8{32'h0F1E_2D3C}}, 2, 3);       // R7 heavy stalls
        run_frame(1, {8{32'hA5A5_5A5A}}, 0, 4);       // R3 low clamp, back-to-back start (R8)
        run_frame(7, {8{32'h8421_1248}}, 0, 5);       // R3 high clamp
        @(negedge clk);
        start_i = 0; coef_valid_i = 0; #1;
        chk(!coef_ready_o && !byte_valid_o, "R8", "idle after last byte",
            {coef_ready_o, byte_valid_o}, 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule